// File: doc/BRIEF.md
# Branch and Subroutine Stack Unit

This unit resolves control flow for a small 8-bit processor core. A one-cycle `start` pulse presents an operation code along with a 3-bit condition mask, the current Z, N and C flags, a 16-bit direct operand, the G and H register bytes, the return address and an optional data byte. The unit then decides whether the branch is taken and hands a new program counter back to the fetch logic. For taken subroutine calls it first saves the return address on an upward-growing stack in byte memory.

The same stack also serves returns, data-byte pushes and pops, and a direct load of the stack pointer. All stack traffic goes through one byte-wide memory port. That port has a one-cycle synchronous read: read data returns in the cycle after the read request. When the program-counter update and all memory traffic are complete, `done` pulses for one cycle. While an operation is in progress `busy` stays high, and any new `start` is ignored.

Top module: `bsu_top`

## Requirements
- R1: Condition mask bit 0 selects Z, bit 1 selects N and bit 2 selects C. A jump or call with a nonzero mask is taken when at least one selected flag is 1, and not taken otherwise.
- R2: A condition mask of 000 makes the jump or call unconditional, whatever the flag values.
- R3: Operation codes are 0 jump-direct, 1 jump-indexed, 2 call-direct, 3 call-indexed, 4 return, 5 load-SP, 6 push-byte and 7 pop-byte. Direct forms take their target from `direct_addr`. Indexed forms use G as the high byte and H as the low byte.
- R4: For a jump, `done` rises in the cycle right after the `start` cycle. When the jump is taken, `pc_load` is high together with `done` and `pc_next` holds the target. When it is not taken, `pc_load` stays low.
- R5: A taken call writes the low byte of `ret_pc` at SP and then the high byte at SP+1, in two consecutive cycles. SP ends 2 higher. `done` and `pc_load` come together, carrying the target, two cycles after the first `done`-capable cycle, that is, a latency of 2.
- R6: A call that is not taken makes no memory access and leaves SP unchanged. It raises `done` with a latency of 0 and keeps `pc_load` low.
- R7: A return reads SP-1 (the high byte) and then SP-2 (the low byte). SP ends 2 lower. `pc_next` becomes {high, low}, with `pc_load` and `done` at a latency of 3.
- R8: Load-SP sets SP to `direct_addr`, with `done` at a latency of 0.
- R9: Push-byte writes `push_byte` at SP and then increments SP, with `done` at a latency of 1.
- R10: Pop-byte decrements SP, reads the byte at the new SP and presents it on `pop_byte` together with `done`, at a latency of 2.
- R11: While `busy` is high, `start` is ignored. `done` is never high while `busy` is high.
- R12: After reset, SP is 0x0000, and `done`, `busy`, `pc_load`, `mem_we` and `mem_re` are all low.

Latency counts the clock cycles between the first cycle after the `start` cycle and the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation request, one cycle |
| op | input | 3 | Operation code |
| cond_mask | input | 3 | Flag selection mask |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| direct_addr | input | 16 | Direct target or new SP value |
| reg_g | input | 8 | G register (indexed high byte) |
| reg_h | input | 8 | H register (indexed low byte) |
| ret_pc | input | 16 | Address after the current instruction |
| push_byte | input | 8 | Data byte for push-byte |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_rdata | input | 8 | Stack memory read data, one cycle after `mem_re` |
| pc_load | output | 1 | Program counter load strobe |
| pc_next | output | 16 | New program counter value |
| sp | output | 16 | Current stack pointer |
| pop_byte | output | 8 | Byte from the last pop-byte |
| done | output | 1 | Operation complete, one cycle |
| busy | output | 1 | Operation in progress |

## Verification
Each operation has a fixed latency. Jumps, calls that are not taken and SP loads complete with a latency of 0. Push-byte completes at 1, a taken call and pop-byte at 2, and a return at 3. The bench raises `start` on a falling edge and drops it on the next falling edge. It then counts falling edges until `done` appears and compares that count with the latency the requirement specifies. It also logs every memory strobe at falling edges, so the order of byte addresses and data can be compared as a sequence rather than checked only at the end.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
   typedef enum logic [2:0] {
      OP_JMP_DIR  = 3'd0,
      OP_JMP_IDX  = 3'd1,
      OP_CALL_DIR = 3'd2,
      OP_CALL_IDX = 3'd3,
      OP_RET      = 3'd4,
      OP_LOAD_SP  = 3'd5,
      OP_PUSH     = 3'd6,
      OP_POP      = 3'd7
   } bsu_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_LO,
      ST_PUSH_HI,
      ST_POP_HI,
      ST_POP_LO,
      ST_POP_WAIT,
      ST_PUSH_DATA,
      ST_POP_DATA
   } bsu_state_e;

   localparam int FLAG_N = 3;
endpackage

// File: rtl/bsu_cond.sv
module bsu_cond #(
   parameter int FLAGS = 3
) (
   input  logic [FLAGS-1:0] mask,
   input  logic [FLAGS-1:0] flags,
   output logic             take
);
   logic [FLAGS-1:0] hit;

   for (genvar i = 0; i < FLAGS; i++) begin : g_hit
      assign hit[i] = mask[i] & flags[i];
   end

   // R1 any selected flag, R2 empty mask means always
   assign take = (mask == '0) | (|hit);
endmodule

// File: rtl/bsu_target.sv
module bsu_target #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              use_idx,
   input  logic [ADDR_W-1:0] direct,
   input  logic [DATA_W-1:0] hi_reg,
   input  logic [DATA_W-1:0] lo_reg,
   output logic [ADDR_W-1:0] target
);
   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("bsu_target: ADDR_W must equal 2*DATA_W");
   end

   assign target = use_idx ? {hi_reg, lo_reg} : direct;
endmodule

// File: rtl/bsu_sp.sv
module bsu_sp #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc,
   input  logic              dec,
   output logic [ADDR_W-1:0] sp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sp <= '0;
      else if (load) sp <= load_val;
      else if (inc)  sp <= sp + ADDR_W'(1);
      else if (dec)  sp <= sp - ADDR_W'(1);
   end

   assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec) && !(load && (inc || dec)));

   assert_sp_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> sp == $past(sp) + ADDR_W'(1));

   assert_sp_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec |=> sp == $past(sp) - ADDR_W'(1));
endmodule

// File: rtl/bsu_top.sv
module bsu_top
   import bsu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [2:0]        cond_mask,
   input  logic              flag_z,
   input  logic              flag_n,
   input  logic              flag_c,
   input  logic [ADDR_W-1:0] direct_addr,
   input  logic [DATA_W-1:0] reg_g,
   input  logic [DATA_W-1:0] reg_h,
   input  logic [ADDR_W-1:0] ret_pc,
   input  logic [DATA_W-1:0] push_byte,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_next,
   output logic [ADDR_W-1:0] sp,
   output logic [DATA_W-1:0] pop_byte,
   output logic              done,
   output logic              busy
);
   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("bsu_top: ADDR_W must equal 2*DATA_W");
   end

   bsu_state_e        state;
   bsu_op_e           op_in, op_q;
   logic [ADDR_W-1:0] tgt_q, ret_q, target;
   logic [DATA_W-1:0] data_q, hi_q;
   logic              take, accept, use_idx, sp_load;

   assign op_in   = bsu_op_e'(op);
   assign accept  = start && (state == ST_IDLE);   // R11
   assign use_idx = (op_in == OP_JMP_IDX) || (op_in == OP_CALL_IDX);
   assign busy    = (state != ST_IDLE);

   bsu_cond #(.FLAGS(FLAG_N)) i_cond (
      .mask  (cond_mask),
      .flags ({flag_c, flag_n, flag_z}),
      .take  (take)
   );

   bsu_target #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_target (
      .use_idx (use_idx),
      .direct  (direct_addr),
      .hi_reg  (reg_g),
      .lo_reg  (reg_h),
      .target  (target)
   );

   assign mem_we  = (state == ST_PUSH_LO) || (state == ST_PUSH_HI) || (state == ST_PUSH_DATA);
   assign mem_re  = (state == ST_POP_HI) || (state == ST_POP_LO) || (state == ST_POP_DATA);
   assign sp_load = accept && (op_in == OP_LOAD_SP);
   assign mem_addr = mem_we ? sp : sp - ADDR_W'(1);

   always_comb begin
      case (state)
         ST_PUSH_LO: mem_wdata = ret_q[DATA_W-1:0];
         ST_PUSH_HI: mem_wdata = ret_q[ADDR_W-1:DATA_W];
         default:    mem_wdata = data_q;
      endcase
   end

   bsu_sp #(.ADDR_W(ADDR_W)) i_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sp_load),
      .load_val (direct_addr),
      .inc      (mem_we),
      .dec      (mem_re),
      .sp       (sp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_q     <= OP_JMP_DIR;
         tgt_q    <= '0;
         ret_q    <= '0;
         data_q   <= '0;
         hi_q     <= '0;
         pc_next  <= '0;
         pop_byte <= '0;
         pc_load  <= 1'b0;
         done     <= 1'b0;
      end else begin
         pc_load <= 1'b0;
         done    <= 1'b0;
         case (state)
            ST_IDLE: if (accept) begin
               op_q   <= op_in;
               tgt_q  <= target;
               ret_q  <= ret_pc;
               data_q <= push_byte;
               case (op_in)
                  OP_JMP_DIR, OP_JMP_IDX: begin
                     pc_next <= target;
                     pc_load <= take;
                     done    <= 1'b1;
                  end
                  OP_CALL_DIR, OP_CALL_IDX: begin
                     if (take) state <= ST_PUSH_LO;
                     else      done  <= 1'b1;
                  end
                  OP_RET:     state <= ST_POP_HI;
                  OP_LOAD_SP: done  <= 1'b1;
                  OP_PUSH:    state <= ST_PUSH_DATA;
                  default:    state <= ST_POP_DATA;
               endcase
            end
            ST_PUSH_LO: state <= ST_PUSH_HI;
            ST_PUSH_HI: begin
               pc_next <= tgt_q;
               pc_load <= 1'b1;
               done    <= 1'b1;
               state   <= ST_IDLE;
            end
            ST_POP_HI: state <= ST_POP_LO;
            ST_POP_LO: begin
               hi_q  <= mem_rdata;
               state <= ST_POP_WAIT;
            end
            ST_POP_WAIT: begin
               if (op_q == OP_RET) begin
                  pc_next <= {hi_q, mem_rdata};
                  pc_load <= 1'b1;
               end else begin
                  pop_byte <= mem_rdata;
               end
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            ST_PUSH_DATA: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_POP_WAIT;   // ST_POP_DATA
         endcase
      end
   end

   assert_one_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_load_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> done);

   assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re));

   assert_push_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PUSH_HI) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

   assert_pop_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_POP_LO) |-> (mem_addr == $past(mem_addr) - ADDR_W'(1)));
endmodule

// File: tb/test_bsu_top.sv
module test_bsu_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = '0, cond_mask = '0;
   logic        flag_z = 1'b0, flag_n = 1'b0, flag_c = 1'b0;
   logic [15:0] direct_addr = '0, ret_pc = '0;
   logic [7:0]  reg_g = '0, reg_h = '0, push_byte = '0;
   logic        mem_we, mem_re, pc_load, done, busy;
   logic [15:0] mem_addr, pc_next, sp;
   logic [7:0]  mem_wdata, pop_byte;
   logic [7:0]  mem_rdata = '0;

   int n_chk = 0, n_fail = 0;
   int lat;
   logic        got_load;
   logic [15:0] got_pc;
   logic [15:0] wr_a [8], rd_a [8];
   logic [7:0]  wr_d [8];
   int nw = 0, nr = 0;
   logic [7:0]  mem [256];

   always #10 clk = ~clk;

   bsu_top i_bsu_top (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_mask(cond_mask),
      .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .direct_addr(direct_addr),
      .reg_g(reg_g), .reg_h(reg_h), .ret_pc(ret_pc), .push_byte(push_byte),
      .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_next(pc_next), .sp(sp),
      .pop_byte(pop_byte), .done(done), .busy(busy)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
   end

   always @(negedge clk) begin
      if (mem_we && nw < 8) begin wr_a[nw] = mem_addr; wr_d[nw] = mem_wdata; nw++; end
      if (mem_re && nr < 8) begin rd_a[nr] = mem_addr; nr++; end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] o, input logic [2:0] m, input logic [2:0] fl_czn,
                        input logic [15:0] d, input logic [7:0] g, input logic [7:0] h,
                        input logic [15:0] r, input logic [7:0] b);
      @(negedge clk);
      nw = 0; nr = 0;
      op = o; cond_mask = m; {flag_c, flag_n, flag_z} = fl_czn;
      direct_addr = d; reg_g = g; reg_h = h; ret_pc = r; push_byte = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 20) begin @(negedge clk); lat++; end
      got_load = pc_load;
      got_pc = pc_next;
   endtask

   task automatic t_reset;
      chk("R12 sp", 32'(sp), 32'h0);
      chk("R12 done/busy/load", {29'd0, done, busy, pc_load}, 32'h0);
      chk("R12 mem strobes", {30'd0, mem_we, mem_re}, 32'h0);
   endtask

   task automatic t_jumps;
      // flags arg is {C,N,Z}
      issue(3'd0, 3'b001, 3'b001, 16'h1111, 8'h0, 8'h0, 16'h0, 8'h0);
      chk("R1 Z taken load", 32'(got_load), 32'h1);
      chk("R4 jump target", 32'(got_pc), 32'h1111);
      chk("R4 jump latency", 32'(lat), 32'd0);
      issue(3'd0, 3'b010, 3'b001, 16'h2222, 8'h0, 8'h0, 16'h0, 8'h0);
      chk("R1 N not set, not taken", 32'(got_load), 32'h0);
      chk("R4 not-taken latency", 32'(lat), 32'd0);
      issue(3'd0, 3'b110, 3'b100, 16'h3333, 8'h0, 8'h0, 16'h0, 8'h0);
      chk("R1 OR of N|C taken", {31'd0, got_load}, 32'h1);
      chk("R1 OR target", 32'(got_pc), 32'h3333);
      issue(3'd0, 3'b000, 3'b000, 16'h4444, 8'h0, 8'h0, 16'h0, 8'h0);
      chk("R2 empty mask taken", 32'(got_load), 32'h1);
      issue(3'd1, 3'b000, 3'b000, 16'hFFFF, 8'h12, 8'h34, 16'h0, 8'h0);
      chk("R3 indexed target G:H", 32'(got_pc), 32'h1234);
   endtask

   task automatic t_load_sp;
      issue(3'd5, 3'b000, 3'b000, 16'h0040, 8'h0, 8'h0, 16'h0, 8'h0);
      chk("R8 sp loaded", 32'(sp), 32'h0040);
      chk("R8 latency", 32'(lat), 32'd0);
   endtask

   task automatic t_call;
      issue(3'd2, 3'b000, 3'b000, 16'h2000, 8'h0, 8'h0, 16'hABCD, 8'h0);
      chk("R5 write count", 32'(nw), 32'd2);
      chk("R5 first addr", 32'(wr_a[0]), 32'h0040);
      chk("R5 first data low", 32'(wr_d[0]), 32'hCD);
      chk("R5 second addr", 32'(wr_a[1]), 32'h0041);
      chk("R5 second data high", 32'(wr_d[1]), 32'hAB);
      chk("R5 sp", 32'(sp), 32'h0042);
      chk("R5 target", 32'(got_pc), 32'h2000);
      chk("R5 load", 32'(got_load), 32'h1);
      chk("R5 latency", 32'(lat), 32'd2);
   endtask

   task automatic t_call_skip;
      issue(3'd3, 3'b100, 3'b011, 16'h0, 8'h55, 8'h66, 16'h9999, 8'h0);
      chk("R6 no writes", 32'(nw), 32'd0);
      chk("R6 sp unchanged", 32'(sp), 32'h0042);
      chk("R6 no load", 32'(got_load), 32'h0);
      chk("R6 latency", 32'(lat), 32'd0);
   endtask

   task automatic t_ret;
      issue(3'd4, 3'b000, 3'b000, 16'h0, 8'h0, 8'h0, 16'h0, 8'h0);
      chk("R7 read count", 32'(nr), 32'd2);
      chk("R7 first read high", 32'(rd_a[0]), 32'h0041);
      chk("R7 second read low", 32'(rd_a[1]), 32'h0040);
      chk("R7 pc", 32'(got_pc), 32'hABCD);
      chk("R7 load", 32'(got_load), 32'h1);
      chk("R7 sp", 32'(sp), 32'h0040);
      chk("R7 latency", 32'(lat), 32'd3);
   endtask

   task automatic t_call_idx;
      issue(3'd3, 3'b001, 3'b001, 16'h0, 8'h7A, 8'h0B, 16'h0123, 8'h0);
      chk("R3 indexed call target", 32'(got_pc), 32'h7A0B);
      chk("R5 indexed call sp", 32'(sp), 32'h0042);
      issue(3'd4, 3'b000, 3'b000, 16'h0, 8'h0, 8'h0, 16'h0, 8'h0);
      chk("R7 return after indexed call", 32'(got_pc), 32'h0123);
   endtask

   task automatic t_bytes;
      issue(3'd6, 3'b000, 3'b000, 16'h0, 8'h0, 8'h0, 16'h0, 8'h5A);
      chk("R9 push latency", 32'(lat), 32'd1);
      chk("R9 push addr", 32'(wr_a[0]), 32'h0040);
      issue(3'd6, 3'b000, 3'b000, 16'h0, 8'h0, 8'h0, 16'h0, 8'hC3);
      chk("R9 sp after pushes", 32'(sp), 32'h0042);
      issue(3'd7, 3'b000, 3'b000, 16'h0, 8'h0, 8'h0, 16'h0, 8'h0);
      chk("R10 pop last", 32'(pop_byte), 32'hC3);
      chk("R10 pop latency", 32'(lat), 32'd2);
      chk("R10 pop addr", 32'(rd_a[0]), 32'h0041);
      chk("R10 pop no pc load", 32'(got_load), 32'h0);
      issue(3'd7, 3'b000, 3'b000, 16'h0, 8'h0, 8'h0, 16'h0, 8'h0);
      chk("R10 pop first", 32'(pop_byte), 32'h5A);
      chk("R10 sp after pops", 32'(sp), 32'h0040);
   endtask

   task automatic t_busy;
      @(negedge clk);
      op = 3'd2; cond_mask = 3'b000; direct_addr = 16'h3000; ret_pc = 16'h0777;
      start = 1'b1;
      @(negedge clk);
      chk("R11 busy during call", 32'(busy), 32'h1);
      op = 3'd5; direct_addr = 16'h0000;   // load-SP attempt while busy
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 20) begin @(negedge clk); lat++; end
      chk("R11 sp load ignored", 32'(sp), 32'h0042);
      chk("R11 call result kept", 32'(pc_next), 32'h3000);
      chk("R11 busy low with done", 32'(busy), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_jumps();
      t_load_sp();
      t_call();
      t_call_skip();
      t_ret();
      t_call_idx();
      t_bytes();
      t_busy();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule